// File: doc/BRIEF.md
# Carry-Save Operand Summing Tree with 4:2 Compressors

This block adds a set of equally aligned unsigned operands into a single binary word. The sum wraps modulo 2^W. The operands arrive together as one packed vector. The block has no clock: the result follows the inputs through combinational logic. A typical use is the accumulation stage of a multiplier, where the partial-product rows have already been shifted into place.

The operand rows are first padded with zero rows, up to a power of two that is at least four. Levels of 4:2 compressor slices then halve the row count at each step, until two rows remain: a sum row and a shifted carry row. A parallel-prefix carry-propagate adder combines those two rows into the final word.

Inside a slice, each bit cell passes a lateral carry to the next more significant cell. That lateral carry is formed only from the cell's first three inputs, so it never waits on the lateral carry that arrives from below. The delay of a level is therefore independent of the operand width. The sum output of a cell passes through three XOR gates.

Top module: `csa42_tree`

## Requirements
- R1: `sum_o` equals the arithmetic sum of all N operands, modulo 2^W, for any operand values.
- R2: In every compressor cell, the sum bit plus twice the carry bit plus twice the lateral carry-out equals the number of ones among the cell's five inputs.
- R3: The lateral carry-out of a cell is 1 exactly when at least two of its first three inputs are 1. It never depends on the lateral carry-in or on the fourth input.
- R4: When N is not a power of two of at least four, the padding rows contribute nothing. With N=3 and W=4, every one of the 4096 operand combinations gives their sum modulo 16.
- R5: When every operand bit is 1, the result is N*(2^W-1) modulo 2^W. This is 16'hFFF8 for 8 operands of 16 bits, and 4'hD for 3 operands of 4 bits.
- R6: The two rows that leave the last compressor level add, modulo 2^W, to the same value as the operand sum.
- R7: With all operands zero, the result is zero.
- R8: A single nonzero operand in any slot i (bits i*W+W-1 down to i*W of `ops_i`) appears unchanged at `sum_o`.
- R9: Carries out of bit W-1 are dropped. Two operands of 16'h8000 give 16'h0000, and eight operands of 16'h2000 give 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | N*W | Packed operands; operand i occupies bits i*W+W-1 down to i*W |
| sum_o | output | W | Sum of all operands modulo 2^W |

## Verification
Every result depends only on the operands presented in the same cycle. No register lies on any path, so each result is due zero cycles after its stimulus. The bench changes the operands just after a rising edge of its pacing clock and reads `sum_o` at the next falling edge. That leaves half a period for the combinational logic to settle, and keeps stimulus and sampling apart from the active edge. Per-cell and last-level relations are checked on every input change by the bound checkers.

// File: rtl/csa42_pkg.sv
package csa42_pkg;

  // Rows entering the tree: the smallest power of two that is >= n and >= 4
  function automatic int pad_rows(input int n);
    int r;
    r = 4;
    while (r < n) r = r * 2;
    return r;
  endfunction

  // Number of 4:2 levels needed to bring `rows` rows down to two
  function automatic int tree_levels(input int rows);
    int r;
    int l;
    r = rows;
    l = 0;
    while (r > 2) begin
      r = r / 2;
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/csa42_cell.sv
// One bit of a 4:2 compressor. The lateral carry-out is formed from
// in0..in2 only. The sum passes through three XOR levels.
module csa42_cell (
  input  logic in0_i,
  input  logic in1_i,
  input  logic in2_i,
  input  logic in3_i,
  input  logic lat_i,
  output logic sum_o,
  output logic cy_o,
  output logic lat_o
);

  logic x01;
  logic x23;
  logic x012;
  logic x0123;

  assign x01   = in0_i ^ in1_i;
  assign x23   = in2_i ^ in3_i;
  assign x0123 = x01 ^ x23;
  assign x012  = x01 ^ in2_i;

  assign sum_o = x0123 ^ lat_i;
  assign lat_o = (in0_i & in1_i) | (in2_i & x01);
  assign cy_o  = x0123 ? lat_i : in3_i;

endmodule

// File: rtl/csa42_row.sv
// A W-bit 4:2 compressor slice: four rows in, a sum row and a carry row out.
module csa42_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] r0_i,
  input  logic [W-1:0] r1_i,
  input  logic [W-1:0] r2_i,
  input  logic [W-1:0] r3_i,
  output logic [W-1:0] sum_row_o,
  output logic [W-1:0] cy_row_o
);

  logic [W-1:0] lat_out;
  logic [W-1:0] lat_in;
  logic [W-1:0] cy;
  logic [W-1:0] s;

  // Lateral carries move one column up; bit 0 takes no lateral carry
  assign lat_in = {lat_out[W-2:0], 1'b0};

  for (genvar i = 0; i < W; i++) begin : g_bit
    csa42_cell u_cell (
      .in0_i (r0_i[i]),
      .in1_i (r1_i[i]),
      .in2_i (r2_i[i]),
      .in3_i (r3_i[i]),
      .lat_i (lat_in[i]),
      .sum_o (s[i]),
      .cy_o  (cy[i]),
      .lat_o (lat_out[i])
    );
  end

  assign sum_row_o = s;
  assign cy_row_o  = {cy[W-2:0], 1'b0};

  // Weight 2^W falls outside the result and is dropped
  logic unused_top;
  assign unused_top = lat_out[W-1] ^ cy[W-1];

endmodule

// File: rtl/ks_adder.sv
// Parallel-prefix carry-propagate adder, result modulo 2^W.
module ks_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);

  localparam int K = $clog2(W);

  for (genvar s = 0; s <= K; s++) begin : g_st
    logic [W-1:0] gg;
    logic [W-1:0] pp;
    if (s == 0) begin : g_init
      assign gg = a_i & b_i;
      assign pp = a_i ^ b_i;
    end else begin : g_comb
      localparam int D = 1 << (s - 1);
      for (genvar i = 0; i < W; i++) begin : g_b
        if (i >= D) begin : g_op
          assign gg[i] = g_st[s-1].gg[i] | (g_st[s-1].pp[i] & g_st[s-1].gg[i-D]);
          assign pp[i] = g_st[s-1].pp[i] & g_st[s-1].pp[i-D];
        end else begin : g_pass
          assign gg[i] = g_st[s-1].gg[i];
          assign pp[i] = g_st[s-1].pp[i];
        end
      end
    end
  end

  assign sum_o = g_st[0].pp ^ {g_st[K].gg[W-2:0], 1'b0};

  logic unused_ks;
  assign unused_ks = ^{g_st[K].pp, g_st[K].gg[W-1]};

endmodule

// File: rtl/csa42_tree.sv
module csa42_tree
  import csa42_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0][W-1:0] ops_i,
  output logic [W-1:0]        sum_o
);

  localparam int R  = pad_rows(N);
  localparam int LV = tree_levels(R);

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int NR = R >> l;
    logic [W-1:0] rows [NR];
    if (l == 0) begin : g_in
      for (genvar j = 0; j < NR; j++) begin : g_row
        if (j < N) begin : g_op
          assign rows[j] = ops_i[j];
        end else begin : g_pad
          assign rows[j] = '0;
        end
      end
    end else begin : g_red
      for (genvar g = 0; g < NR / 2; g++) begin : g_grp
        csa42_row #(.W(W)) u_row (
          .r0_i      (g_lvl[l-1].rows[4*g]),
          .r1_i      (g_lvl[l-1].rows[4*g+1]),
          .r2_i      (g_lvl[l-1].rows[4*g+2]),
          .r3_i      (g_lvl[l-1].rows[4*g+3]),
          .sum_row_o (rows[2*g]),
          .cy_row_o  (rows[2*g+1])
        );
      end
    end
  end

  logic [W-1:0] fin_a;
  logic [W-1:0] fin_b;
  assign fin_a = g_lvl[LV].rows[0];
  assign fin_b = g_lvl[LV].rows[1];

  ks_adder #(.W(W)) u_cpa (
    .a_i   (fin_a),
    .b_i   (fin_b),
    .sum_o (sum_o)
  );

endmodule

// File: rtl/csa42_tree_chk.sv
module csa42_cell_chk (
  input logic in0,
  input logic in1,
  input logic in2,
  input logic in3,
  input logic lat_in,
  input logic s,
  input logic cy,
  input logic lat_out
);

  int ones_in;
  int first3;
  int weight_out;

  always_comb begin
    ones_in    = int'(in0) + int'(in1) + int'(in2) + int'(in3) + int'(lat_in);
    first3     = int'(in0) + int'(in1) + int'(in2);
    weight_out = int'(s) + 2 * (int'(cy) + int'(lat_out));
  end

  always_comb begin
    a_r2_cell_count: assert (weight_out == ones_in)
      else $error("R2 cell weight %0d, inputs hold %0d ones", weight_out, ones_in);
    a_r3_lat_no_ripple: assert (lat_out == (first3 >= 2))
      else $error("R3 lateral carry %0b with %0d ones in first three", lat_out, first3);
  end

endmodule

module csa42_tree_chk #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic [N-1:0][W-1:0] ops_i,
  input logic [W-1:0]        sum_o,
  input logic [W-1:0]        fin_a,
  input logic [W-1:0]        fin_b
);

  logic [W-1:0] ref_sum;
  logic [W-1:0] pair_sum;
  logic [W-1:0] ones_val;

  always_comb begin
    ref_sum = '0;
    for (int k = 0; k < N; k++) ref_sum = ref_sum + ops_i[k];
    pair_sum = fin_a + fin_b;
    ones_val = '0;
    for (int k = 0; k < N; k++) ones_val = ones_val - W'(1);
  end

  always_comb begin
    a_r1_sum_exact: assert (sum_o == ref_sum)
      else $error("R1 sum %0h, expected %0h", sum_o, ref_sum);
    a_r6_last_rows: assert (pair_sum == ref_sum)
      else $error("R6 last rows add to %0h, expected %0h", pair_sum, ref_sum);
    if (ops_i == '0) begin
      a_r7_zero: assert (sum_o == '0)
        else $error("R7 zero operands gave %0h", sum_o);
    end
    if (&ops_i) begin
      a_r5_all_ones: assert (sum_o == ones_val)
        else $error("R5 all-ones gave %0h, expected %0h", sum_o, ones_val);
    end
  end

endmodule

bind csa42_cell csa42_cell_chk u_cell_chk (
  .in0     (in0_i),
  .in1     (in1_i),
  .in2     (in2_i),
  .in3     (in3_i),
  .lat_in  (lat_i),
  .s       (sum_o),
  .cy      (cy_o),
  .lat_out (lat_o)
);

bind csa42_tree csa42_tree_chk #(.N(N), .W(W)) u_tree_chk (
  .ops_i (ops_i),
  .sum_o (sum_o),
  .fin_a (fin_a),
  .fin_b (fin_b)
);

// File: tb/test_csa42_tree.sv
module test_csa42_tree;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int NS = 3;
  localparam int WS = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [N-1:0][W-1:0]   ops;
  logic [W-1:0]          sum;
  logic [NS-1:0][WS-1:0] ops_s;
  logic [WS-1:0]         sum_s;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  csa42_tree #(.N(N), .W(W)) i_csa42_tree (
    .ops_i (ops),
    .sum_o (sum)
  );

  csa42_tree #(.N(NS), .W(WS)) i_csa42_tree_small (
    .ops_i (ops_s),
    .sum_o (sum_s)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_sum(input logic [N-1:0][W-1:0] v);
    logic [31:0] acc;
    acc = 0;
    for (int k = 0; k < N; k++) acc = acc + 32'(v[k]);
    return acc[W-1:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ops   = '0;
    ops_s = '0;
    @(negedge clk);
    chk(32'(sum),   0, "R7 zero operands (wide)");
    chk(32'(sum_s), 0, "R7 zero operands (small)");

    // R8: one set bit walked through every slot and position
    for (int k = 0; k < N; k++) begin
      for (int b = 0; b < W; b++) begin
        @(posedge clk);
        ops    = '0;
        ops[k] = W'(1) << b;
        @(negedge clk);
        chk(32'(sum), 32'(W'(1) << b), "R8 single operand pass-through");
      end
    end

    // R5: all ones
    @(posedge clk);
    ops   = '1;
    ops_s = '1;
    @(negedge clk);
    chk(32'(sum),   32'h0000_FFF8, "R5 all-ones wide");
    chk(32'(sum_s), 32'h0000_000D, "R5 all-ones small");

    // R9: wrap at the top column
    @(posedge clk);
    ops    = '0;
    ops[0] = 16'h8000;
    ops[1] = 16'h8000;
    @(negedge clk);
    chk(32'(sum), 0, "R9 top carry dropped (two 8000)");
    @(posedge clk);
    for (int k = 0; k < N; k++) ops[k] = 16'h2000;
    @(negedge clk);
    chk(32'(sum), 0, "R9 top carry dropped (eight 2000)");

    // R4: exhaustive over the padded three-operand configuration
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 16; c++) begin
          @(posedge clk);
          ops_s[0] = WS'(a);
          ops_s[1] = WS'(b);
          ops_s[2] = WS'(c);
          @(negedge clk);
          chk(32'(sum_s), 32'((a + b + c) % 16), "R4 padded rows exhaustive");
        end
      end
    end

    // R1 R2 R3 R6: random operand sets, all cells and both last rows in use
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      for (int k = 0; k < N; k++) begin
        if (i % 10 == 0) ops[k] = '1;
        else              ops[k] = W'($urandom);
      end
      if (i % 10 == 0) ops[i % N] = W'($urandom);
      @(negedge clk);
      chk(32'(sum), 32'(model_sum(ops)), "R1 R2 R3 R6 random operand sum");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule